// File: doc/BRIEF.md
# Two-Line Anti-Tamper Metering Selector

This block sits between the power calculators of a two-current-channel energy meter and its pulse accumulator. It receives signed active and reactive power for the live line (L) and the neutral line (N). On each power-update strobe it decides which line's power, or their sum, is passed on. In the anti-tamper mode it tracks a current metering line. It moves to the other line only when that line's active power exceeds the present line's by more than a programmable percentage. This gives hysteresis around the threshold. A separate rule applies when both lines carry low power.

The other three modes pin the output to L, sum both lines, or follow a select bit. Only active power drives the decision. The reactive output always comes from the same line as the active output. The threshold code is a plain input; the system should drive it with code 14 (3.125 %) unless it has been configured otherwise.

Top module: `line_tamper_sel`

## Requirements
- R1: With `mode` = 01 a strobe loads `p_out` = `p_l`, `q_out` = `q_l` and clears `on_n`.
- R2: With `mode` = 10 a strobe loads `p_out` = `p_l` + `p_n` and `q_out` = `q_l` + `q_n`, both full-width signed sums, and clears `on_n`.
- R3: With `mode` = 11 a strobe selects N when `line_pick` = 1 and L when it is 0; `on_n` equals `line_pick`.
- R4: During reset, and after it until the first strobe, `p_out`, `q_out` and `on_n` are 0, and the tamper line is L.
- R5: With `mode` = 00 and L current, a strobe moves to N only if (|p_n| − |p_l|)·10^6 > T·|p_l|, with T in ppm. Otherwise L is kept.
- R6: With `mode` = 00 and N current, a strobe moves to L only if (|p_l| − |p_n|)·10^6 > T·|p_n|. Otherwise N is kept.
- R7: `thr_code` k gives T = (k+1)·10000 ppm for k = 0..11. Code 12 gives 125000, code 13 gives 62500, code 14 gives 31250 and code 15 gives 15625.
- R8: With `mode` = 00, the percentage rule is replaced when both |p_l| and |p_n| are strictly above `start_th` and strictly below 8·`start_th`. In that case the line with the larger magnitude is chosen, and a tie keeps the current line.
- R9: The mode-00 decision uses magnitudes. A zero reference power counts as exceeded whenever the other line is nonzero.
- R10: In modes 00, 01 and 11, `q_out` is the reactive power of the line whose active power is in `p_out`, and `on_n` = 1 marks that line as N.
- R11: Without a strobe, `p_out`, `q_out` and `on_n` hold their values whatever the other inputs do.
- R12: A strobe in any mode other than 00 returns the tamper line to L, so the next mode-00 decision starts from L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd | input | 1 | Power-update strobe; one decision per high cycle |
| mode | input | 2 | 00 anti-tamper, 01 fixed L, 10 sum, 11 select |
| line_pick | input | 1 | Line choice in mode 11 (1 = N) |
| thr_code | input | 4 | Switching threshold code |
| start_th | input | PW | Startup power, unsigned |
| p_l | input | PW | L active power, signed |
| p_n | input | PW | N active power, signed |
| q_l | input | PW | L reactive power, signed |
| q_n | input | PW | N reactive power, signed |
| p_out | output | PW+1 | Selected active power, signed |
| q_out | output | PW+1 | Selected reactive power, signed |
| on_n | output | 1 | Output taken from N |

## Verification
The assertions assume that power inputs are sampled only when `upd` is high. They also assume that `start_th` is small enough that 8·`start_th` fits in PW+3 bits, which holds for any PW-bit value.

The stimulus changes inputs only on the falling clock edge and pulses `upd` for a single cycle. It keeps powers inside the signed PW-bit range, including both extremes. This means the arithmetic the checker recomputes never wraps.

// File: rtl/line_tamper_sel.sv
module line_tamper_sel #(
  parameter int PW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic [1:0]           mode,
  input  logic                 line_pick,
  input  logic [3:0]           thr_code,
  input  logic [PW-1:0]        start_th,
  input  logic signed [PW-1:0] p_l,
  input  logic signed [PW-1:0] p_n,
  input  logic signed [PW-1:0] q_l,
  input  logic signed [PW-1:0] q_n,
  output logic signed [PW:0]   p_out,
  output logic signed [PW:0]   q_out,
  output logic                 on_n
);
  localparam int MW = PW + 21;
  localparam int OW = PW + 1;
  localparam int BW = PW + 3;

  function automatic logic [PW-1:0] mag(input logic [PW-1:0] v);
    return v[PW-1] ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [16:0] ppm(input logic [3:0] c);
    case (c)
      4'd12:   return 17'd125000;
      4'd13:   return 17'd62500;
      4'd14:   return 17'd31250;
      4'd15:   return 17'd15625;
      default: return 17'(({13'd0, c} + 17'd1) * 17'd10000);
    endcase
  endfunction

  function automatic logic beats(input logic [PW-1:0] big, input logic [PW-1:0] ref_p,
                                 input logic [16:0] t);
    logic [MW-1:0] lhs, rhs;
    lhs = MW'(big - ref_p) * MW'(1000000);
    rhs = MW'(t) * MW'(ref_p);
    return (big > ref_p) && (lhs > rhs);
  endfunction

  logic [PW-1:0] al, an;
  logic [16:0]   thr;
  logic [BW-1:0] st8;
  logic          low_band, cur_n, tam_nx;

  assign al  = mag(p_l);
  assign an  = mag(p_n);
  assign thr = ppm(thr_code);
  assign st8 = {start_th, 3'b000};
  assign low_band = (al > start_th) && (an > start_th) &&
                    (BW'(al) < st8) && (BW'(an) < st8);

  always_comb begin
    if (low_band)
      tam_nx = (an > al) ? 1'b1 : ((al > an) ? 1'b0 : cur_n);
    else if (!cur_n)
      tam_nx = beats(an, al, thr);
    else
      tam_nx = !beats(al, an, thr);
  end

  logic              use_n;
  logic signed [OW-1:0] sum_p, sum_q;

  assign use_n = (mode == 2'b00) ? tam_nx : ((mode == 2'b11) ? line_pick : 1'b0);
  assign sum_p = OW'(p_l) + OW'(p_n);
  assign sum_q = OW'(q_l) + OW'(q_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_n <= 1'b0;
      on_n  <= 1'b0;
      p_out <= '0;
      q_out <= '0;
    end else if (upd) begin
      cur_n <= (mode == 2'b00) ? tam_nx : 1'b0;
      on_n  <= use_n;
      if (mode == 2'b10) begin
        p_out <= sum_p;
        q_out <= sum_q;
      end else begin
        p_out <= use_n ? OW'(p_n) : OW'(p_l);
        q_out <= use_n ? OW'(q_n) : OW'(q_l);
      end
    end
  end
endmodule

module line_tamper_sel_chk #(
  parameter int PW = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 upd,
  input logic [1:0]           mode,
  input logic                 line_pick,
  input logic [PW-1:0]        start_th,
  input logic signed [PW-1:0] p_l,
  input logic signed [PW-1:0] p_n,
  input logic signed [PW-1:0] q_l,
  input logic signed [PW-1:0] q_n,
  input logic signed [PW:0]   p_out,
  input logic signed [PW:0]   q_out,
  input logic                 on_n
);
  logic [PW-1:0] ml, mn;
  logic          band;
  assign ml   = p_l[PW-1] ? (~p_l + 1'b1) : p_l;
  assign mn   = p_n[PW-1] ? (~p_n + 1'b1) : p_n;
  assign band = (ml > start_th) && (mn > start_th) &&
                ({3'b000, ml} < {start_th, 3'b000}) && ({3'b000, mn} < {start_th, 3'b000});

  // R1
  fixed_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mode == 2'b01) |=> (!on_n && p_out == $signed($past(p_l)) && q_out == $signed($past(q_l))));
  // R2
  sum_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mode == 2'b10) |=> (!on_n && p_out == $signed({$past(p_l[PW-1]), $past(p_l)}) + $signed({$past(p_n[PW-1]), $past(p_n)})));
  // R3
  pick_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mode == 2'b11) |=> (on_n == $past(line_pick)));
  // R8
  low_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mode == 2'b00 && band && mn > ml) |=> on_n);
  // R10
  react_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mode != 2'b10) |=> (q_out == (on_n ? $signed($past(q_n)) : $signed($past(q_l)))));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(on_n) && $stable(p_out) && $stable(q_out)));
endmodule

bind line_tamper_sel line_tamper_sel_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .mode(mode), .line_pick(line_pick),
  .start_th(start_th), .p_l(p_l), .p_n(p_n), .q_l(q_l), .q_n(q_n),
  .p_out(p_out), .q_out(q_out), .on_n(on_n)
);

// File: tb/line_tamper_sel_test.sv
`timescale 1ns/1ps
module line_tamper_sel_test;
  localparam int PW = 24;
  logic clk = 1'b0, rst_n = 1'b0, upd = 1'b0, line_pick = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [3:0] thr_code = 4'd14;
  logic [PW-1:0] start_th = '0;
  logic signed [PW-1:0] p_l = '0, p_n = '0, q_l = '0, q_n = '0;
  logic signed [PW:0] p_out, q_out;
  logic on_n;
  int checks = 0, fails = 0;
  bit ref_cur = 1'b0;

  always #2.5 clk = ~clk;

  line_tamper_sel #(.PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .upd(upd), .mode(mode), .line_pick(line_pick),
    .thr_code(thr_code), .start_th(start_th), .p_l(p_l), .p_n(p_n), .q_l(q_l), .q_n(q_n),
    .p_out(p_out), .q_out(q_out), .on_n(on_n)
  );

  function automatic longint tppm(int c);
    if (c < 12) return longint'(c + 1) * 10000;
    case (c)
      12: return 125000;
      13: return 62500;
      14: return 31250;
      default: return 15625;
    endcase
  endfunction

  function automatic longint absv(longint v);
    return v < 0 ? -v : v;
  endfunction

  function automatic bit model_nx(bit cur, longint a, longint n, longint st, int c);
    longint t = tppm(c);
    if (a > st && n > st && a < 8 * st && n < 8 * st)
      return n > a ? 1'b1 : (a > n ? 1'b0 : cur);
    if (!cur) return (n > a) && ((n - a) * 1000000 > t * a);
    return !((a > n) && ((a - n) * 1000000 > t * n));
  endfunction

  task automatic check(string tag, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic strobe(string tag, logic [1:0] m, logic pk, int c, longint st,
                        longint pl, longint pn, longint ql, longint qn);
    bit nx;
    longint ep, eq;
    @(negedge clk);
    mode = m; line_pick = pk; thr_code = 4'(c); start_th = PW'(st);
    p_l = PW'(pl); p_n = PW'(pn); q_l = PW'(ql); q_n = PW'(qn);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    case (m)
      2'b00: nx = model_nx(ref_cur, absv(pl), absv(pn), st, c);
      2'b11: nx = pk;
      default: nx = 1'b0;
    endcase
    ref_cur = (m == 2'b00) ? nx : 1'b0;
    if (m == 2'b10) begin ep = pl + pn; eq = ql + qn; end
    else begin ep = nx ? pn : pl; eq = nx ? qn : ql; end
    check(tag, longint'(on_n), longint'(nx), "on_n");
    check(tag, longint'(p_out), ep, "p_out");
    check(tag, longint'(q_out), eq, "q_out");
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    longint maxp = (longint'(1) << (PW - 1)) - 1;
    longint minp = -(longint'(1) << (PW - 1));
    longint lo [5] = '{1000, 1001, 3000, 7999, 8000};
    repeat (3) @(negedge clk);
    // R4 reset state
    check("R4", longint'(on_n), 0, "on_n");
    check("R4", longint'(p_out), 0, "p_out");
    check("R4", longint'(q_out), 0, "q_out");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R4", longint'(on_n), 0, "on_n after release");

    // R1 R2 R3 R10: non-tamper modes over sign and range extremes
    for (int i = 0; i < 4; i++) begin
      longint vals [4] = '{0, -7, maxp, minp};
      for (int j = 0; j < 4; j++) begin
        strobe("R1", 2'b01, 1'b1, 0, 0, vals[i], vals[j], vals[j], vals[i]);
        strobe("R2", 2'b10, 1'b0, 0, 0, vals[i], vals[j], vals[j], vals[i]);
        strobe("R3", 2'b11, 1'b1, 0, 0, vals[i], vals[j], vals[j], vals[i]);
        strobe("R10", 2'b11, 1'b0, 0, 0, vals[i], vals[j], vals[j], vals[i]);
      end
    end

    // R5 R6 R7 R9: threshold boundary for every code, both directions, both signs
    for (int c = 0; c < 16; c++)
      for (int dir = 0; dir < 2; dir++)
        for (int off = -1; off <= 1; off++)
          for (int sg = 0; sg < 2; sg++) begin
            longint base = 200000;
            longint d = tppm(c) / 5 + off;
            longint s = sg ? -1 : 1;
            strobe("R12", 2'b01, 1'b0, c, 100, 5, 6, 7, 8);
            if (dir) begin
              strobe("R5", 2'b00, 1'b0, c, 100, 100000, 200000, 1, 2);
              strobe("R6", 2'b00, 1'b0, c, 100, s * (base + d), -s * base, 11, -22);
            end else
              strobe("R7", 2'b00, 1'b0, c, 100, -s * base, s * (base + d), 33, -44);
          end

    // R8 low power band, both starting lines, ties included
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int dir = 0; dir < 2; dir++) begin
          strobe("R12", 2'b01, 1'b0, 14, 1000, 0, 0, 0, 0);
          if (dir) strobe("R5", 2'b00, 1'b0, 14, 1000, 10, 90000, 0, 0);
          strobe("R8", 2'b00, 1'b0, 14, 1000, lo[a], -lo[b], 3, 4);
        end

    // R9 zero reference
    strobe("R12", 2'b01, 1'b0, 0, 0, 0, 0, 0, 0);
    strobe("R9", 2'b00, 1'b0, 11, 0, 0, 0, 1, 2);
    strobe("R9", 2'b00, 1'b0, 11, 0, 0, -1, 1, 2);
    strobe("R9", 2'b00, 1'b0, 11, 0, 1, 0, 3, 4);

    // R12 leaving mode 00 forgets N
    strobe("R5", 2'b00, 1'b0, 14, 0, 10, 1000, 5, 6);
    strobe("R12", 2'b11, 1'b1, 14, 0, 10, 1000, 5, 6);
    strobe("R12", 2'b00, 1'b0, 14, 0, 1000, 1000, 5, 6);

    // R11 hold without strobe
    strobe("R11", 2'b11, 1'b1, 3, 0, 123, -456, 789, -12);
    @(negedge clk);
    mode = 2'b10; line_pick = 1'b0; p_l = 999; p_n = -999; q_l = 5; q_n = 6;
    repeat (4) @(negedge clk);
    check("R11", longint'(on_n), 1, "on_n held");
    check("R11", longint'(p_out), -456, "p_out held");
    check("R11", longint'(q_out), -12, "q_out held");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule